// File: doc/BRIEF.md
# Serial ADC Power-Mode Sequencer

This block sits on the host side of a serial sampling converter. The converter's power state is chosen by how long chip-select stays low within a conversion frame. The block accepts three kinds of request: take a sample, put the converter to sleep, or wake it. It drives chip-select and an idle-high serial clock. It shifts in the 16-bit frame on serial-clock falling edges and hands out only samples that can be trusted.

A frame that releases chip-select after two falling edges, well before the tenth, sends the converter to sleep. A frame that holds chip-select low for all sixteen falling edges keeps it awake. The first frame after any power-up is a throwaway. A sample request made while the converter is asleep, or while its state is still unknown after supply-on, first runs that throwaway frame. The block then waits out the quiet gap and runs the real frame, without further requests. A tracked power mode is visible at the ports.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, cs_n=1, sclk=1, ready=1, dout_valid=0 and mode=0. The mode encoding is 0 unknown, 1 shut down, 2 waking, 3 normal.
- R2: A sample request while mode is 0 or 1 runs two frames. The first is a 16-falling-edge throwaway that produces no strobe, with mode 2 during it. The second is a 16-falling-edge frame that produces one strobe. Mode is 3 afterwards.
- R3: A sample request while mode is 3 runs one 16-falling-edge frame. It ends with one dout_valid strobe, and dout holds the 16 bits sampled on successive falling edges, first bit as the MSB (bit 15).
- R4: A shutdown request runs a frame of exactly 2 sclk falling edges. Chip-select rises with the sclk rise that follows. No strobe is produced and mode becomes 1.
- R5: A wake request runs one 16-falling-edge throwaway frame with no strobe. Mode becomes 3.
- R6: Between any two frames, cs_n stays high for exactly QUIET system cycles. ready is low from the accepting cycle until that gap ends.
- R7: Requests are taken only when ready is high and are otherwise ignored. When several are raised together, shutdown wins over wake, and wake wins over sample.
- R8: dout_valid is a one-cycle strobe. It is raised only at the end of a non-throwaway sample frame, in the cycle chip-select rises.
- R9: Each sclk low phase lasts DIV system cycles. sclk is high whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_conv | input | 1 | Request one valid sample |
| req_shdn | input | 1 | Request shutdown |
| req_wake | input | 1 | Request wake-up |
| sdata | input | 1 | Serial data from the converter |
| ready | output | 1 | High when a request can be taken |
| cs_n | output | 1 | Chip-select to the converter, active low |
| sclk | output | 1 | Serial clock, idle high |
| dout | output | 16 | Last valid captured word |
| dout_valid | output | 1 | One-cycle strobe for a new valid word |
| mode | output | 2 | Tracked power mode (0 unknown, 1 shut down, 2 waking, 3 normal) |

## Verification
A wrong tracked mode shows up at the next sample request. Either the frame count is wrong, because a throwaway frame is missing or an extra one appears, or the strobe arrives with throwaway data. Either way it is seen within two frames of the request. A bad falling-edge count shows in the frame where it occurs: chip-select rises after the wrong number of edges, or the captured word is shifted. A miscounted quiet gap shows at the very next frame start, as a chip-select high run of the wrong length.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int DIV         = 2,
  parameter int QUIET       = 4,
  parameter int BITS        = 16,
  parameter int SHORT_FALLS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_conv,
  input  logic            req_shdn,
  input  logic            req_wake,
  input  logic            sdata,
  output logic            ready,
  output logic            cs_n,
  output logic            sclk,
  output logic [BITS-1:0] dout,
  output logic            dout_valid,
  output logic [1:0]      mode
);
  localparam int DW = $clog2(DIV + 1);
  localparam int QW = $clog2(QUIET + 1);
  localparam int FW = $clog2(BITS + 1);
  localparam logic [1:0] M_UNK = 2'd0, M_SHDN = 2'd1, M_WAKE = 2'd2, M_NORM = 2'd3;
  localparam logic [1:0] K_DUMMY = 2'd0, K_REAL = 2'd1, K_SHORT = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_QUIET} st_t;

  st_t             st;
  logic [1:0]      kind;
  logic            pend;
  logic [DW-1:0]   div_cnt;
  logic [QW-1:0]   q_cnt;
  logic [FW-1:0]   falls;
  logic [BITS-1:0] sh;

  wire          tick     = div_cnt == DW'(DIV - 1);
  wire [FW-1:0] last_cnt = (kind == K_SHORT) ? FW'(SHORT_FALLS) : FW'(BITS);
  wire          any_req  = req_conv | req_shdn | req_wake;

  assign ready = st == ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      kind       <= K_DUMMY;
      pend       <= 1'b0;
      div_cnt    <= '0;
      q_cnt      <= '0;
      falls      <= '0;
      sh         <= '0;
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      dout       <= '0;
      dout_valid <= 1'b0;
      mode       <= M_UNK;
    end else begin
      dout_valid <= 1'b0;
      case (st)
        ST_IDLE: if (any_req) begin
          st      <= ST_FRAME;
          cs_n    <= 1'b0;
          sclk    <= 1'b1;
          div_cnt <= '0;
          falls   <= '0;
          pend    <= 1'b0;
          if (req_shdn) kind <= K_SHORT;
          else if (req_wake) begin
            kind <= K_DUMMY;
            mode <= M_WAKE;
          end else if (mode == M_NORM) kind <= K_REAL;
          else begin
            kind <= K_DUMMY;
            mode <= M_WAKE;
            pend <= 1'b1;
          end
        end
        ST_FRAME: if (tick) begin
          div_cnt <= '0;
          if (sclk) begin
            sclk  <= 1'b0;
            sh    <= {sh[BITS-2:0], sdata};
            falls <= falls + 1'b1;
          end else begin
            sclk <= 1'b1;
            if (falls == last_cnt) begin
              cs_n  <= 1'b1;
              st    <= ST_QUIET;
              q_cnt <= '0;
              case (kind)
                K_REAL: begin
                  dout       <= sh;
                  dout_valid <= 1'b1;
                end
                K_SHORT: mode <= M_SHDN;
                default: mode <= M_NORM;
              endcase
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        ST_QUIET: if (q_cnt == QW'(QUIET - 1)) begin
          q_cnt <= '0;
          if (pend) begin
            pend    <= 1'b0;
            kind    <= K_REAL;
            st      <= ST_FRAME;
            cs_n    <= 1'b0;
            div_cnt <= '0;
            falls   <= '0;
          end else begin
            st <= ST_IDLE;
          end
        end else begin
          q_cnt <= q_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int QUIET       = 4,
  parameter int BITS        = 16,
  parameter int SHORT_FALLS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_conv,
  input logic       req_shdn,
  input logic       req_wake,
  input logic       ready,
  input logic       cs_n,
  input logic       sclk,
  input logic       dout_valid,
  input logic [1:0] mode
);
  logic [31:0] hi_cnt;
  logic [31:0] nf;
  logic        sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 32'(QUIET);
      nf     <= '0;
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        if (hi_cnt < 32'(QUIET)) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt <= '0;
      end
      if (cs_n) nf <= '0;
      else if (sclk_q && !sclk) nf <= nf + 1;
    end
  end

  a_r9_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  a_r6_ready_means_idle: assert property (@(posedge clk) disable iff (!rst_n) ready |-> cs_n);
  a_r6_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> hi_cnt >= 32'(QUIET));
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n) dout_valid |=> !dout_valid);
  a_r8_valid_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n) dout_valid |-> $rose(cs_n) && mode == 2'd3);
  a_r4_short_frame: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) && mode == 2'd1 |-> nf == 32'(SHORT_FALLS));
  a_r2_full_frame: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) && mode == 2'd3 |-> nf == 32'(BITS));
  a_r7_mode_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !(req_conv || req_shdn || req_wake) |=> $stable(mode));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.QUIET(QUIET), .BITS(BITS), .SHORT_FALLS(SHORT_FALLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_conv(req_conv), .req_shdn(req_shdn), .req_wake(req_wake),
  .ready(ready), .cs_n(cs_n), .sclk(sclk), .dout_valid(dout_valid), .mode(mode)
);

// File: tb/adc_pwr_seq_bench.sv
module adc_pwr_seq_bench;
  localparam int DIV = 2, QUIET = 4, BITS = 16;

  logic clk = 0, rst_n = 0;
  logic req_conv = 0, req_shdn = 0, req_wake = 0, sdata = 0;
  logic ready, cs_n, sclk, dout_valid;
  logic [BITS-1:0] dout;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;

  adc_pwr_seq #(.DIV(DIV), .QUIET(QUIET), .BITS(BITS)) u_adc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_conv(req_conv), .req_shdn(req_shdn), .req_wake(req_wake),
    .sdata(sdata), .ready(ready), .cs_n(cs_n), .sclk(sclk), .dout(dout),
    .dout_valid(dout_valid), .mode(mode));

  always #2 clk = ~clk;

  logic [BITS-1:0] word = '0, sent_last = '0;
  int bit_idx = 0;
  always @(negedge cs_n) begin
    word = 16'($urandom);
    sent_last = word;
    bit_idx = BITS - 1;
    sdata = word[bit_idx];
  end
  always @(posedge sclk) if (!cs_n && bit_idx > 0) begin
    bit_idx = bit_idx - 1;
    sdata = word[bit_idx];
  end

  int frames = 0, valids = 0, cur_falls = 0, fmin = 99, fmax = 0;
  int gap = 0, last_gap = -1, low_run = 0, phase_bad = 0, idle_bad = 0;
  logic [BITS-1:0] last_dout = '0;
  logic prev_cs = 1, prev_sclk = 1;
  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      frames++;
      cur_falls = 0;
      last_gap = gap;
    end
    if (!cs_n && prev_sclk && !sclk) cur_falls++;
    if (!prev_cs && cs_n) begin
      if (cur_falls < fmin) fmin = cur_falls;
      if (cur_falls > fmax) fmax = cur_falls;
      gap = 0;
    end
    if (cs_n) gap++;
    if (!sclk) low_run++;
    else if (!prev_sclk) begin
      if (low_run != DIV) phase_bad++;
      low_run = 0;
    end
    if (cs_n && !sclk) idle_bad++;
    if (dout_valid) begin
      valids++;
      last_dout = dout;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_frames(input bit c, input bit s, input bit w, input logic [1:0] m);
    if (s || w) return 1;
    return (m == 2'd3) ? 1 : 2;
  endfunction
  function automatic int exp_valids(input bit s, input bit w);
    return (s || w) ? 0 : 1;
  endfunction
  function automatic int exp_falls(input bit s);
    return s ? 2 : BITS;
  endfunction
  function automatic int exp_mode(input bit s);
    return s ? 1 : 3;
  endfunction

  task automatic run_op(input bit c, input bit s, input bit w, input string tag);
    int f0, v0;
    logic [1:0] m0;
    bit saw_wake;
    while (!ready) @(negedge clk);
    f0 = frames; v0 = valids; m0 = mode;
    fmin = 99; fmax = 0; saw_wake = 0;
    req_conv = c; req_shdn = s; req_wake = w;
    @(negedge clk);
    req_conv = 0; req_shdn = 0; req_wake = 0;
    check(!ready, "R6", {tag, " ready low after accept"}, ready, 0);
    while (!ready) begin
      if (mode == 2'd2) saw_wake = 1;
      @(negedge clk);
    end
    check(frames - f0 == exp_frames(c, s, w, m0), tag, "frame count", frames - f0, exp_frames(c, s, w, m0));
    check(valids - v0 == exp_valids(s, w), tag, "strobe count", valids - v0, exp_valids(s, w));
    check(fmin == exp_falls(s) && fmax == exp_falls(s), tag, "falling edges per frame", fmax, exp_falls(s));
    check(mode == 2'(exp_mode(s)), tag, "mode after", mode, exp_mode(s));
    if (exp_valids(s, w) == 1)
      check(last_dout == sent_last, "R3", {tag, " captured word"}, last_dout, sent_last);
    if (exp_frames(c, s, w, m0) == 2) begin
      check(last_gap == QUIET, "R6", {tag, " quiet gap"}, last_gap, QUIET);
      check(saw_wake, "R2", {tag, " waking mode seen"}, saw_wake, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(cs_n && sclk && ready && !dout_valid && mode == 2'd0, "R1", "reset state",
          {cs_n, sclk, ready, dout_valid, mode}, 6'b111000);
    rst_n = 1;
    @(negedge clk);
    run_op(1, 0, 0, "R2 sample from unknown");
    run_op(1, 0, 0, "R3 sample in normal");
    run_op(1, 1, 0, "R7 priority shutdown over sample");
    run_op(1, 0, 0, "R2 sample from shutdown");
    run_op(0, 0, 1, "R5 wake from normal");
    run_op(0, 1, 1, "R7 priority shutdown over wake");
    run_op(1, 0, 1, "R5 R7 wake over sample");
    run_op(0, 1, 0, "R4 shutdown");
    begin
      int f0;
      while (!ready) @(negedge clk);
      req_conv = 1; @(negedge clk); req_conv = 0;
      repeat (5) @(negedge clk);
      req_wake = 1; req_shdn = 1; @(negedge clk); req_wake = 0; req_shdn = 0;
      while (!ready) @(negedge clk);
      f0 = frames;
      check(mode == 2'd3, "R7", "mode after ignored request", mode, 3);
      repeat (12) @(negedge clk);
      check(frames == f0 && cs_n, "R7", "no frame from ignored request", frames - f0, 0);
    end
    for (int i = 0; i < 40; i++) begin
      logic [2:0] r;
      r = 3'($urandom_range(1, 7));
      run_op(r[0], r[1], r[2], "R2 R3 R4 R5 random");
    end
    check(phase_bad == 0, "R9", "sclk low phase length", phase_bad, 0);
    check(idle_bad == 0, "R9", "sclk high while idle", idle_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule